// File: doc/BRIEF.md
# NAND ECC Offload Engine Register Block

This block is the host-facing register file of a NAND error-correction offload engine. A host reaches it through a 32-bit register port with a valid/ready handshake. Through that port the host sets the engine's enable and correction-strength index, and programs the chunk count and the main-area and spare-area DMA addresses. It also starts one chunk of processing in a chosen direction and reads a fixed version number. The correction arithmetic and the DMA mover are outside the block: the block gives them a one-cycle start strobe and takes back a one-cycle done pulse and five progress events.

Interrupt handling has two enable layers. A status-enable mask decides whether an incoming event is recorded in the status register. A separate signal-enable mask decides whether a recorded bit drives the single level interrupt output. Status bits are cleared by writing ones to them, so a host can clear exactly what it has just read by writing that value back. The start bit of the DMA control register stays set while a chunk is in flight and drops by itself when the done pulse arrives.

Top module: `ecc_ctl_regs`

## Requirements
- R1: After reset every register reads zero except the version register, and `irq_o`, `xfer_start_o` and `cfg_en_o` are low.
- R2: The configuration register (offset 0x00) keeps only bit 0 (engine enable) and bits 6:3 (strength index). All other bits read as zero. `cfg_en_o` and `cfg_strength_o` follow the stored value.
- R3: Status bits sit at offset 0x04: bit 0 transfer complete, bit 1 main DMA, bit 2 spare DMA, bit 3 ECC error, bit 4 to-spare, bit 5 to-main. `events_i[0..4]` feed bits 1..5 in that order. An event sets its bit only if the same bit of the status-enable register (0x08) is 1.
- R4: A write to the status register clears each bit written as 1 and leaves every bit written as 0. Writing back a value just read returns the register to zero.
- R5: `irq_o` is high exactly when some status bit is set and the same bit of the signal-enable register (0x0C) is 1. The signal-enable register has no effect on whether status bits latch.
- R6: A write to the DMA control register (0x40) with bit 31 set, while the engine is enabled and idle, starts a chunk. `xfer_start_o` is high for exactly the one cycle after the write. Bit 31 then reads 1, and bit 1 reads back and drives `xfer_read_o` (1 = read, 0 = write).
- R7: A `xfer_done_i` pulse during a chunk clears bit 31 of the DMA control register and sets status bit 0 if its status-enable bit is 1. A done pulse while idle has no effect.
- R8: A start write while the engine-enable bit is 0 is ignored: no strobe, no status, and the DMA control register is unchanged.
- R9: A start write while a chunk is already in flight is ignored: no second strobe, and the direction is unchanged.
- R10: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R11: The chunk count (0x30, low CNT_W bits) and the main (0x44) and spare (0x48) addresses read back what was written and drive their outputs. The version register (0xD0) returns VERSION in bits 31:16 and ignores writes. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted (always ready) |
| reg_rdata | output | 32 | Read data, valid in the same cycle as a read request |
| events_i | input | 5 | Progress event pulses for status bits 1..5 |
| xfer_done_i | input | 1 | Done pulse from the transfer engine |
| xfer_start_o | output | 1 | One-cycle chunk start strobe |
| xfer_read_o | output | 1 | Chunk direction, 1 = read |
| cfg_en_o | output | 1 | Engine enable |
| cfg_strength_o | output | 4 | Correction strength index |
| chunk_cnt_o | output | CNT_W | Chunk count |
| main_addr_o | output | 32 | Main-area DMA address |
| spare_addr_o | output | 32 | Spare-area DMA address |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can meet in one cycle: a host write-one-to-clear of the status register, and a new hardware event on the same bit. The bench drives an event pulse on the spare-DMA line in the same clock as a write of 1 to that bit. It then reads the status register, which must show the bit still set. A second collision is a start write that lands while a chunk is in flight. Reading back the control register and watching the strobe must show that the first chunk's direction survives and that no second strobe is issued.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

    localparam int STAT_N  = 6;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STEN = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SGEN = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_CCNT = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_DMA  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_MADR = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_SADR = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_VER  = 8'hD0;

    localparam int START_BIT = 31;
    localparam int DIR_BIT   = 1;
    localparam int EN_BIT    = 0;
    localparam int STR_LSB   = 3;
    localparam int STR_W     = 4;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_STAT,
        SEL_STEN,
        SEL_SGEN,
        SEL_CCNT,
        SEL_DMA,
        SEL_MADR,
        SEL_SADR,
        SEL_VER
    } reg_sel_e;

    typedef struct packed {
        logic [STR_W-1:0] strength;
        logic             en;
    } cfg_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CFG:  return SEL_CFG;
            OFF_STAT: return SEL_STAT;
            OFF_STEN: return SEL_STEN;
            OFF_SGEN: return SEL_SGEN;
            OFF_CCNT: return SEL_CCNT;
            OFF_DMA:  return SEL_DMA;
            OFF_MADR: return SEL_MADR;
            OFF_SADR: return SEL_SADR;
            OFF_VER:  return SEL_VER;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT] = c.en;
        w[STR_LSB +: STR_W] = c.strength;
        return w;
    endfunction

    function automatic cfg_t word_cfg(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.en       = w[EN_BIT];
        c.strength = w[STR_LSB +: STR_W];
        return c;
    endfunction

endpackage

// File: rtl/ecc_reg_decode.sv
module ecc_reg_decode
    import ecc_regs_pkg::*;
(
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic              wr_o,
    output logic              rd_o
);
    always_comb begin
        sel_o = valid_i ? decode_offset(addr_i) : SEL_NONE;
        wr_o  = valid_i &  write_i;
        rd_o  = valid_i & ~write_i;
    end
endmodule

// File: rtl/ecc_int_status.sv
module ecc_int_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stat_i,
    input  logic         wr_sten_i,
    input  logic         wr_sgen_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] sten_o,
    output logic [N-1:0] sgen_o,
    output logic         irq_o
);
    logic [N-1:0] status_q;
    logic [N-1:0] sten_q;
    logic [N-1:0] sgen_q;
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;

    assign set_v = src_i & sten_q;
    assign clr_v = wr_stat_i ? wdata_i : '0;

    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[k] <= 1'b0;
            end else if (set_v[k]) begin
                status_q[k] <= 1'b1;
            end else if (clr_v[k]) begin
                status_q[k] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sten_q <= '0;
            sgen_q <= '0;
        end else begin
            if (wr_sten_i) sten_q <= wdata_i;
            if (wr_sgen_i) sgen_q <= wdata_i;
        end
    end

    assign status_o = status_q;
    assign sten_o   = sten_q;
    assign sgen_o   = sgen_q;
    assign irq_o    = |(status_q & sgen_q);

    // R3
    status_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((status_q & $past(set_v)) == $past(set_v)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_v == 1'b0) |=> ((status_q & ~$past(status_q)) == '0));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_v & ~set_v) != '0) |=> ((status_q & $past(clr_v & ~set_v)) == '0));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_v & set_v) != '0) |=> ((status_q & $past(clr_v & set_v)) == $past(clr_v & set_v)));
endmodule

// File: rtl/ecc_xfer_ctrl.sv
module ecc_xfer_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr_dma_i,
    input  logic start_bit_i,
    input  logic dir_bit_i,
    input  logic eng_en_i,
    input  logic done_i,
    output logic busy_o,
    output logic dir_o,
    output logic start_o,
    output logic done_evt_o
);
    logic busy_q;
    logic dir_q;
    logic start_q;
    logic accept;
    logic take_dir;

    assign accept   = wr_dma_i & start_bit_i & eng_en_i & ~busy_q;
    assign take_dir = wr_dma_i & ~busy_q & (~start_bit_i | eng_en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            dir_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= accept;
            if (take_dir) dir_q <= dir_bit_i;
            if (accept) begin
                busy_q <= 1'b1;
            end else if (done_i && busy_q) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy_o     = busy_q;
    assign dir_o      = dir_q;
    assign start_o    = start_q;
    assign done_evt_o = done_i & busy_q;

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |-> ($past(eng_en_i) && busy_q));

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && done_i) |=> !busy_q);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_i) |=> (busy_q && $stable(dir_q)));
endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
    import ecc_regs_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter logic [15:0] VERSION = 16'h0003
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ready,
    output logic [31:0]       reg_rdata,
    input  logic [4:0]        events_i,
    input  logic              xfer_done_i,
    output logic              xfer_start_o,
    output logic              xfer_read_o,
    output logic              cfg_en_o,
    output logic [3:0]        cfg_strength_o,
    output logic [CNT_W-1:0]  chunk_cnt_o,
    output logic [31:0]       main_addr_o,
    output logic [31:0]       spare_addr_o,
    output logic              irq_o
);
    reg_sel_e sel;
    logic     wr;
    logic     rd;

    cfg_t             cfg_q;
    logic [CNT_W-1:0] ccnt_q;
    logic [31:0]      madr_q;
    logic [31:0]      sadr_q;

    logic [STAT_N-1:0] status;
    logic [STAT_N-1:0] sten;
    logic [STAT_N-1:0] sgen;
    logic [STAT_N-1:0] src;
    logic              busy;
    logic              dir;
    logic              done_evt;

    ecc_reg_decode u_dec (
        .valid_i (reg_valid),
        .write_i (reg_write),
        .addr_i  (reg_addr),
        .sel_o   (sel),
        .wr_o    (wr),
        .rd_o    (rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            ccnt_q <= '0;
            madr_q <= '0;
            sadr_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CFG:  cfg_q  <= word_cfg(reg_wdata);
                SEL_CCNT: ccnt_q <= reg_wdata[CNT_W-1:0];
                SEL_MADR: madr_q <= reg_wdata;
                SEL_SADR: sadr_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    assign src = {events_i, done_evt};

    ecc_int_status #(.N(STAT_N)) u_int (
        .clk       (clk),
        .rst       (rst),
        .wr_stat_i (wr && sel == SEL_STAT),
        .wr_sten_i (wr && sel == SEL_STEN),
        .wr_sgen_i (wr && sel == SEL_SGEN),
        .wdata_i   (reg_wdata[STAT_N-1:0]),
        .src_i     (src),
        .status_o  (status),
        .sten_o    (sten),
        .sgen_o    (sgen),
        .irq_o     (irq_o)
    );

    ecc_xfer_ctrl u_xfer (
        .clk         (clk),
        .rst         (rst),
        .wr_dma_i    (wr && sel == SEL_DMA),
        .start_bit_i (reg_wdata[START_BIT]),
        .dir_bit_i   (reg_wdata[DIR_BIT]),
        .eng_en_i    (cfg_q.en),
        .done_i      (xfer_done_i),
        .busy_o      (busy),
        .dir_o       (dir),
        .start_o     (xfer_start_o),
        .done_evt_o  (done_evt)
    );

    always_comb begin
        reg_rdata = '0;
        if (rd) begin
            case (sel)
                SEL_CFG:  reg_rdata = cfg_word(cfg_q);
                SEL_STAT: reg_rdata = 32'(status);
                SEL_STEN: reg_rdata = 32'(sten);
                SEL_SGEN: reg_rdata = 32'(sgen);
                SEL_CCNT: reg_rdata = 32'(ccnt_q);
                SEL_DMA: begin
                    reg_rdata[START_BIT] = busy;
                    reg_rdata[DIR_BIT]   = dir;
                end
                SEL_MADR: reg_rdata = madr_q;
                SEL_SADR: reg_rdata = sadr_q;
                SEL_VER:  reg_rdata = {VERSION, 16'h0000};
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign reg_ready      = 1'b1;
    assign xfer_read_o    = dir;
    assign cfg_en_o       = cfg_q.en;
    assign cfg_strength_o = cfg_q.strength;
    assign chunk_cnt_o    = ccnt_q;
    assign main_addr_o    = madr_q;
    assign spare_addr_o   = sadr_q;

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status != '0 && sgen != '0));

    // R7
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && xfer_done_i && sten[0]) |=> status[0]);
endmodule

// File: tb/ecc_ctl_regs_bench.sv
module ecc_ctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ready;
    logic [31:0] reg_rdata;
    logic [4:0]  events_i = '0;
    logic        xfer_done_i = 1'b0;
    logic        xfer_start_o;
    logic        xfer_read_o;
    logic        cfg_en_o;
    logic [3:0]  cfg_strength_o;
    logic [15:0] chunk_cnt_o;
    logic [31:0] main_addr_o;
    logic [31:0] spare_addr_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    ecc_ctl_regs u_ecc_ctl_regs (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
        .reg_rdata(reg_rdata), .events_i(events_i), .xfer_done_i(xfer_done_i),
        .xfer_start_o(xfer_start_o), .xfer_read_o(xfer_read_o),
        .cfg_en_o(cfg_en_o), .cfg_strength_o(cfg_strength_o),
        .chunk_cnt_o(chunk_cnt_o), .main_addr_o(main_addr_o),
        .spare_addr_o(spare_addr_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic pulse_events(input logic [4:0] m);
        @(negedge clk); events_i = m;
        @(negedge clk); events_i = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done_i = 1'b1;
        @(negedge clk); xfer_done_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 cfg", v, 0);
        rd(8'h04, v); check("R1 status", v, 0);
        rd(8'h08, v); check("R1 sten", v, 0);
        rd(8'h0C, v); check("R1 sgen", v, 0);
        rd(8'h30, v); check("R1 ccnt", v, 0);
        rd(8'h40, v); check("R1 dma", v, 0);
        rd(8'h44, v); check("R1 madr", v, 0);
        check("R1 outs", {irq_o, xfer_start_o, cfg_en_o}, 0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R2 all ones", v, 32'h79);
        check("R2 outs", {cfg_en_o, cfg_strength_o}, 5'h1F);
        wr(8'h00, 32'h0000_0011);
        rd(8'h00, v); check("R2 idx2", v, 32'h11);
        check("R2 strength", cfg_strength_o, 2);
    endtask

    task automatic t_latch_w1c();
        logic [31:0] v;
        pulse_events(5'h1F);
        rd(8'h04, v); check("R3 masked", v, 0);
        wr(8'h08, 32'h3F);
        pulse_events(5'b10101);
        rd(8'h04, v); check("R3 latch", v, 32'h2A);
        wr(8'h04, 32'h08);
        rd(8'h04, v); check("R4 partial", v, 32'h22);
        wr(8'h04, v);
        rd(8'h04, v); check("R4 writeback", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(8'h0C, 32'h04);
        check("R5 idle", irq_o, 0);
        pulse_events(5'b00010);
        check("R5 raised", irq_o, 1);
        wr(8'h0C, 32'h00);
        check("R5 masked", irq_o, 0);
        rd(8'h04, v); check("R5 still latched", v, 32'h04);
        wr(8'h04, 32'h3F);
        rd(8'h04, v); check("R4 clear all", v, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk);
        events_i = 5'b00010;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h04;
        @(negedge clk);
        events_i = '0; reg_valid = 1'b0; reg_write = 1'b0;
        rd(8'h04, v); check("R10 set wins", v, 32'h04);
        wr(8'h04, 32'h04);
        rd(8'h04, v); check("R10 later clear", v, 0);
    endtask

    task automatic t_start_disabled();
        logic [31:0] v;
        wr(8'h00, 32'h10);
        wr(8'h40, 32'h8000_0002);
        check("R8 no strobe", xfer_start_o, 0);
        rd(8'h40, v); check("R8 dma unchanged", v, 0);
        rd(8'h04, v); check("R8 no status", v, 0);
        pulse_done();
        rd(8'h04, v); check("R7 idle done", v, 0);
    endtask

    task automatic t_start_run();
        logic [31:0] v;
        wr(8'h00, 32'h11);
        wr(8'h40, 32'h8000_0002);
        check("R6 strobe", xfer_start_o, 1);
        check("R6 dir out", xfer_read_o, 1);
        @(negedge clk);
        check("R6 strobe one cycle", xfer_start_o, 0);
        rd(8'h40, v); check("R6 busy readback", v, 32'h8000_0002);
        wr(8'h40, 32'h8000_0000);
        check("R9 no second strobe", xfer_start_o, 0);
        rd(8'h40, v); check("R9 dir kept", v, 32'h8000_0002);
        rd(8'h04, v); check("R7 pending", v, 0);
        pulse_done();
        rd(8'h40, v); check("R7 self clear", v, 32'h0000_0002);
        rd(8'h04, v); check("R7 complete", v, 32'h01);
        wr(8'h0C, 32'h01);
        check("R5 done irq", irq_o, 1);
        wr(8'h04, 32'h01);
        check("R4 irq drop", irq_o, 0);
        wr(8'h40, 32'h8000_0000);
        check("R6 write dir", xfer_read_o, 0);
        rd(8'h40, v); check("R6 write readback", v, 32'h8000_0000);
        pulse_done();
    endtask

    task automatic t_misc();
        logic [31:0] v;
        wr(8'h30, 32'hABCD_1234);
        rd(8'h30, v); check("R11 ccnt", v, 32'h1234);
        check("R11 ccnt out", chunk_cnt_o, 16'h1234);
        wr(8'h44, 32'h1000_0400);
        wr(8'h48, 32'h2000_0020);
        rd(8'h44, v); check("R11 madr", v, 32'h1000_0400);
        rd(8'h48, v); check("R11 sadr", v, 32'h2000_0020);
        check("R11 addr outs", main_addr_o ^ spare_addr_o, 32'h3000_0420);
        wr(8'hD0, 32'hFFFF_FFFF);
        rd(8'hD0, v); check("R11 version", v, 32'h0003_0000);
        rd(8'h20, v); check("R11 unmapped", v, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        rd(8'hD0, reg_wdata);
        check("R1 version", reg_wdata, 32'h0003_0000);
        check("R1 ready", reg_ready, 1);
        t_config();
        t_latch_w1c();
        t_irq();
        t_collide();
        t_start_disabled();
        t_start_run();
        t_misc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule